// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block behaves as the device end of a three-wire serial EEPROM with a 2048-bit array. The array is seen either as 128 words of 16 bits or as 256 bytes, and a width-select input chooses the view. A fast system clock samples the chip-select, serial-clock and data-in lines through synchronizers. The output line is presented as a data value plus an output enable, so that a pad or a bench can build the tri-state pin from them.

A frame opens with a start bit of 1. Two opcode bits and an address field follow. The block supports sequential reads with a leading zero bit and automatic address advance. It also supports single-word erase and write, whole-array erase and fill, and a pair of commands that lock and unlock programming. Each program operation starts when chip-select falls after a complete frame. A timer of a set number of system clocks then runs the operation, and while chip-select is high the output line shows a busy or ready level.

Top module: `serial_eeprom_model`

## Requirements
- R1: A frame is a 1 start bit, two opcode bits sent MSB first, then an address field of one don't-care bit followed by the address, MSB first. In 16-bit mode the address is 7 bits, so the frame is 11 bits. In 8-bit mode it is 8 bits, so the frame is 12 bits. Zeros sent before the start bit are skipped.
- R2: Opcode 10 is a read. On the serial-clock rise that takes the last address bit, the output is driven to 0 as a dummy bit. On each later rise the next data bit appears, MSB first. The 16-bit view gives 16 bits per word and the 8-bit view gives 8.
- R3: A read keeps going while chip-select stays high. The address steps by one after each word, and it wraps from 127 to 0 in the 16-bit view and from 255 to 0 in the 8-bit view. In the 8-bit view, byte address b names word b>>1, and bit 0 of b picks the high byte (1) or the low byte (0).
- R4: After reset, programming is locked, every word reads all ones, and the output enable is low.
- R5: Opcode 00 with top address bits 11 unlocks programming, and with 00 it locks programming. Erase (11), write (01), whole-array erase (00 with 10) and whole-array fill (00 with 01) do nothing while programming is locked. Reads work in either state.
- R6: A program command takes effect only when chip-select falls after the full frame, including the data bits for write and fill. A frame that is cut short is dropped, and no timer starts.
- R7: Erase sets the addressed word or byte to all ones. Write replaces the addressed word or byte with the data bits that follow the address. Whole-array erase sets every word to all ones. Whole-array fill stores the data in every word, or in every byte in the 8-bit view.
- R8: While a program cycle runs and chip-select is high, the output is enabled and low. Once the cycle ends it goes high. Whenever chip-select is low, the output enable is low.
- R9: A start bit that arrives while a program cycle runs is ignored, and so is the frame that follows it.
- R10: A program cycle lasts exactly PROG_CYCLES system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_x16_i | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
First, every word address is written with an arithmetic pattern. One sequential read then starts two words below the top and runs across the wrap, which separates a correct address step from an off-by-one or a missing wrap. The same contents are read back as 256 bytes in the 8-bit view, which exposes swapped byte lanes and a wrong header length. Other stimuli run whole-array commands, single-byte writes, truncated frames, leading zeros, frames sent while locked, and an unlock-lock frame sent during a busy cycle. These separate the gating, launch and ignore rules from the storage path.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_ERASE, K_WRITE, K_ERAL, K_WRAL, K_EWEN, K_EWDS
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_READ, S_DONE
  } fst_t;

  // Opcode plus the two top address bits select the command.
  function automatic kind_t decode_op(logic [1:0] op, logic [1:0] ext);
    kind_t k;
    case (op)
      2'b10:   k = K_READ;
      2'b11:   k = K_ERASE;
      2'b01:   k = K_WRITE;
      default: begin
        case (ext)
          2'b11:   k = K_EWEN;
          2'b00:   k = K_EWDS;
          2'b10:   k = K_ERAL;
          default: k = K_WRAL;
        endcase
      end
    endcase
    return k;
  endfunction

  function automatic logic takes_data(kind_t k);
    return (k == K_WRITE) || (k == K_WRAL);
  endfunction

  function automatic logic is_program(kind_t k);
    return (k == K_ERASE) || (k == K_WRITE) || (k == K_ERAL) || (k == K_WRAL);
  endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/eep_frame.sv
module eep_frame
  import eep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              sk_rise,
  input  logic              di,
  input  logic              org_x16,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              rd_active,
  output logic              rd_bit,
  output logic              frame_start,
  output logic              frame_idle,
  output logic              launch,
  output kind_t             l_kind,
  output logic [ADDR_W:0]   l_addr,
  output logic [WORD_W-1:0] l_data,
  output logic              l_org
);
  localparam int BA_W    = ADDR_W + 1;
  localparam int HDR_MAX = ADDR_W + 4;
  localparam int BYTE_W  = WORD_W / 2;
  localparam int CNT_MAX = (HDR_MAX > WORD_W) ? HDR_MAX : WORD_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  function automatic logic [CNT_W-1:0] hdr_len(logic o);
    return o ? CNT_W'(ADDR_W + 3) : CNT_W'(ADDR_W + 4);
  endfunction

  function automatic logic [CNT_W-1:0] word_len(logic o);
    return o ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
  endfunction

  function automatic logic [ADDR_W-1:0] word_idx(logic [BA_W-1:0] a, logic o);
    return o ? a[ADDR_W-1:0] : a[BA_W-1:1];
  endfunction

  function automatic logic [BA_W-1:0] step(logic [BA_W-1:0] a, logic o);
    logic [ADDR_W-1:0] w;
    w = a[ADDR_W-1:0] + 1'b1;
    return o ? {1'b0, w} : a + 1'b1;
  endfunction

  // Left-align the selected unit so its MSB sits in the top bit.
  function automatic logic [WORD_W-1:0] align(logic [WORD_W-1:0] w,
                                              logic [BA_W-1:0] a, logic o);
    logic [BYTE_W-1:0] b;
    b = a[0] ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    return o ? w : {b, {BYTE_W{1'b0}}};
  endfunction

  fst_t                st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HDR_MAX-1:0]  hdr_q;
  logic [WORD_W-1:0]   dat_q;
  logic [WORD_W-1:0]   rsh_q;
  logic [CNT_W-1:0]    rleft_q;
  logic                first_q;
  logic                do_q;
  logic                org_q;
  kind_t               kind_q;
  logic [BA_W-1:0]     addr_q;

  logic [HDR_MAX-1:0]  hdr_nx;
  logic [1:0]          dec_op;
  logic [1:0]          dec_ext;
  logic [BA_W-1:0]     dec_addr;
  kind_t               dec_kind;
  logic [BA_W-1:0]     fetch_addr;
  logic [WORD_W-1:0]   fetch_word;

  always_comb begin
    hdr_nx = {hdr_q[HDR_MAX-2:0], di};
    if (org_q) begin
      dec_op   = hdr_nx[ADDR_W+2:ADDR_W+1];
      dec_ext  = hdr_nx[ADDR_W:ADDR_W-1];
      dec_addr = {1'b0, hdr_nx[ADDR_W-1:0]};
    end else begin
      dec_op   = hdr_nx[ADDR_W+3:ADDR_W+2];
      dec_ext  = hdr_nx[ADDR_W+1:ADDR_W];
      dec_addr = hdr_nx[ADDR_W:0];
    end
    dec_kind = decode_op(dec_op, dec_ext);
  end

  assign fetch_addr = first_q ? addr_q : step(addr_q, org_q);
  assign rd_idx     = word_idx(fetch_addr, org_q);
  assign fetch_word = align(rd_word, fetch_addr, org_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      hdr_q       <= '0;
      dat_q       <= '0;
      rsh_q       <= '0;
      rleft_q     <= '0;
      first_q     <= 1'b0;
      do_q        <= 1'b0;
      org_q       <= 1'b1;
      kind_q      <= K_NONE;
      addr_q      <= '0;
      launch      <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      launch      <= 1'b0;
      frame_start <= 1'b0;
      if (!cs_lvl) begin
        st_q  <= S_IDLE;
        cnt_q <= '0;
        if (cs_fall && st_q == S_DONE && !busy) launch <= 1'b1;
      end else if (sk_rise) begin
        case (st_q)
          S_IDLE: begin
            if (di && !busy) begin
              st_q        <= S_HDR;
              cnt_q       <= '0;
              hdr_q       <= '0;
              org_q       <= org_x16;
              frame_start <= 1'b1;
            end
          end
          S_HDR: begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == hdr_len(org_q)) begin
              kind_q <= dec_kind;
              addr_q <= dec_addr;
              cnt_q  <= '0;
              if (dec_kind == K_READ) begin
                st_q    <= S_READ;
                do_q    <= 1'b0;
                rleft_q <= '0;
                first_q <= 1'b1;
              end else if (takes_data(dec_kind)) begin
                st_q  <= S_DATA;
                dat_q <= '0;
              end else begin
                st_q <= S_DONE;
              end
            end
          end
          S_DATA: begin
            dat_q <= {dat_q[WORD_W-2:0], di};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == word_len(org_q)) st_q <= S_DONE;
          end
          S_READ: begin
            if (rleft_q != '0) begin
              do_q    <= rsh_q[WORD_W-1];
              rsh_q   <= {rsh_q[WORD_W-2:0], 1'b0};
              rleft_q <= rleft_q - 1'b1;
            end else begin
              do_q    <= fetch_word[WORD_W-1];
              rsh_q   <= {fetch_word[WORD_W-2:0], 1'b0};
              rleft_q <= word_len(org_q) - 1'b1;
              addr_q  <= fetch_addr;
              first_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active  = (st_q == S_READ);
  assign rd_bit     = do_q;
  assign frame_idle = (st_q == S_IDLE);
  assign l_kind     = kind_q;
  assign l_addr     = addr_q;
  assign l_data     = dat_q;
  assign l_org      = org_q;
endmodule

// File: rtl/eep_prog.sv
module eep_prog
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  kind_t             l_kind,
  input  logic [ADDR_W:0]   l_addr,
  input  logic [WORD_W-1:0] l_data,
  input  logic              l_org,
  input  logic              frame_start,
  input  logic              cs_fall,
  output logic              busy,
  output logic              wr_en,
  output logic              status,
  output logic              we,
  output logic              we_all,
  output logic [ADDR_W-1:0] we_idx,
  output logic [WORD_W-1:0] we_mask,
  output logic [WORD_W-1:0] we_data
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int TMR_W  = $clog2(PROG_CYCLES + 1);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(PROG_CYCLES - 1);

  function automatic logic [WORD_W-1:0] lane(logic hi);
    return hi ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  endfunction

  logic [TMR_W-1:0]  tmr_q;
  kind_t             kq;
  logic [ADDR_W:0]   aq;
  logic [WORD_W-1:0] dq;
  logic              oq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wr_en  <= 1'b0;
      status <= 1'b0;
      tmr_q  <= '0;
      kq     <= K_NONE;
      aq     <= '0;
      dq     <= '0;
      oq     <= 1'b1;
    end else begin
      if (frame_start || (cs_fall && !busy)) status <= 1'b0;
      if (launch) begin
        if (l_kind == K_EWEN) wr_en <= 1'b1;
        else if (l_kind == K_EWDS) wr_en <= 1'b0;
        else if (is_program(l_kind) && wr_en) begin
          busy   <= 1'b1;
          status <= 1'b1;
          tmr_q  <= '0;
          kq     <= l_kind;
          aq     <= l_addr;
          dq     <= l_data;
          oq     <= l_org;
        end
      end
      if (busy) begin
        if (tmr_q == LAST) busy <= 1'b0;
        else tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign we = busy && (tmr_q == LAST);

  always_comb begin
    logic [WORD_W-1:0] dup;
    dup     = {dq[BYTE_W-1:0], dq[BYTE_W-1:0]};
    we_idx  = oq ? aq[ADDR_W-1:0] : aq[ADDR_W:1];
    we_all  = 1'b0;
    we_mask = '0;
    we_data = '0;
    case (kq)
      K_ERASE: begin
        we_mask = oq ? '1 : lane(aq[0]);
        we_data = '1;
      end
      K_WRITE: begin
        we_mask = oq ? '1 : lane(aq[0]);
        we_data = oq ? dq : dup;
      end
      K_ERAL: begin
        we_all  = 1'b1;
        we_mask = '1;
        we_data = '1;
      end
      K_WRAL: begin
        we_all  = 1'b1;
        we_mask = '1;
        we_data = oq ? dq : dup;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] we_idx,
  input  logic [WORD_W-1:0] we_mask,
  input  logic [WORD_W-1:0] we_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  hit;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    assign hit[r] = we && (we_all || we_idx == ADDR_W'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) mem[r] <= '1;
    end else begin
      for (int r = 0; r < DEPTH; r++)
        if (hit[r]) mem[r] <= (mem[r] & ~we_mask) | (we_data & we_mask);
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_x16_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0] s_lvl, s_rise, s_fall;
  logic cs_lvl, cs_fall, sk_rise, di_lvl;

  eep_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_i, sk_i, di_i}),
    .lvl_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall)
  );
  assign cs_lvl  = s_lvl[2];
  assign cs_fall = s_fall[2];
  assign sk_rise = s_rise[1];
  assign di_lvl  = s_lvl[0];

  logic [ADDR_W-1:0] rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              rd_active, rd_bit, frame_start, frame_idle, launch, l_org;
  kind_t             l_kind;
  logic [ADDR_W:0]   l_addr;
  logic [WORD_W-1:0] l_data;
  logic              busy, wr_en, status, we, we_all;
  logic [ADDR_W-1:0] we_idx;
  logic [WORD_W-1:0] we_mask, we_data;

  eep_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .di(di_lvl), .org_x16(org_x16_i), .busy(busy),
    .rd_word(rd_word), .rd_idx(rd_idx), .rd_active(rd_active),
    .rd_bit(rd_bit), .frame_start(frame_start), .frame_idle(frame_idle),
    .launch(launch), .l_kind(l_kind), .l_addr(l_addr), .l_data(l_data),
    .l_org(l_org)
  );

  eep_prog #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .launch(launch), .l_kind(l_kind),
    .l_addr(l_addr), .l_data(l_data), .l_org(l_org),
    .frame_start(frame_start), .cs_fall(cs_fall), .busy(busy),
    .wr_en(wr_en), .status(status), .we(we), .we_all(we_all),
    .we_idx(we_idx), .we_mask(we_mask), .we_data(we_data)
  );

  eep_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .we_all(we_all), .we_idx(we_idx),
    .we_mask(we_mask), .we_data(we_data), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  assign do_oe_o = cs_lvl & (rd_active | status);
  assign do_o    = rd_active ? rd_bit : ~busy;
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int PROG_CYCLES = 500000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_lvl,
  input logic busy,
  input logic wr_en,
  input logic rd_active,
  input logic frame_idle,
  input logic do_o,
  input logic do_oe_o
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else busy_run <= busy ? busy_run + 1 : '0;
  end

  p_dummy_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (do_oe_o && !do_o));

  p_locked_no_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  p_start_after_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs_lvl, 2));

  p_busy_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_lvl) |-> (do_oe_o && !do_o));

  p_ready_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cs_lvl) |-> (do_oe_o && do_o));

  p_no_frame_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> frame_idle);

  p_cycle_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == PROG_CYCLES));
endmodule

bind serial_eeprom_model eep_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .busy(busy), .wr_en(wr_en),
  .rd_active(rd_active), .frame_idle(frame_idle), .do_o(do_o),
  .do_oe_o(do_oe_o)
);

// File: tb/test_serial_eeprom_model.sv
module test_serial_eeprom_model;
  localparam int H  = 4;
  localparam int PC = 200;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_w, oe_w;
  logic samp_do, samp_oe;
  logic [15:0] shadow [128];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  serial_eeprom_model #(.ADDR_W(7), .WORD_W(16), .PROG_CYCLES(PC)) i_serial_eeprom_model (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .org_x16_i(org), .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(logic b);
    di = b; tick(H);
    sk = 1'b1; tick(H);
    samp_do = do_w; samp_oe = oe_w;
    sk = 1'b0;
  endtask

  task automatic bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bitx(v[i]);
  endtask

  function automatic logic [8:0] ext_raw(logic o, logic [1:0] e);
    return o ? {1'b0, e, 6'b0} : {e, 7'b0};
  endfunction

  task automatic header(logic o, logic [1:0] op, logic [8:0] raw, int lead);
    org = o; cs = 1'b1; tick(H);
    bits(0, lead);
    bitx(1'b1);
    bits({30'b0, op}, 2);
    bits({23'b0, raw}, o ? 8 : 9);
  endtask

  task automatic prog_cmd(logic o, logic [1:0] op, logic [8:0] raw,
                          logic [15:0] d, int nd, int lead);
    header(o, op, raw, lead);
    if (nd > 0) bits({16'b0, d}, nd);
    cs = 1'b0;
  endtask

  // R8 / R10: high-Z while deselected, busy low, ready after PC clocks
  task automatic wait_prog(string tag);
    int n;
    tick(8); n = 8;
    chk(!oe_w, {"R8 hi-z deselected ", tag}, oe_w, 0);
    cs = 1'b1; tick(6); n += 6;
    chk(oe_w && !do_w, {"R8 busy low ", tag}, {oe_w, do_w}, 2'b10);
    while (!(oe_w && do_w) && n < PC + 100) begin tick(1); n++; end
    chk(n >= PC && n <= PC + 8, {"R10 cycle length ", tag}, n, PC);
    cs = 1'b0; tick(2 * H);
  endtask

  task automatic no_launch(string tag);
    tick(8); cs = 1'b1; tick(6);
    chk(!oe_w, tag, oe_w, 0);
    cs = 1'b0; tick(2 * H);
  endtask

  function automatic logic [7:0] shadow_byte(int b);
    return b[0] ? shadow[b >> 1][15:8] : shadow[b >> 1][7:0];
  endfunction

  task automatic read_seq(logic o, int a0, int n, string tag);
    int a;
    logic [15:0] v;
    logic [15:0] e;
    header(o, 2'b10, 9'(a0), 0);
    chk(samp_oe && !samp_do, {"R2 dummy zero ", tag}, {samp_oe, samp_do}, 2'b10);
    a = a0;
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 0; i < (o ? 16 : 8); i++) begin
        bitx(1'b0);
        v = {v[14:0], samp_do};
      end
      e = o ? shadow[a] : {8'h00, shadow_byte(a)};
      chk(v == e, {"R3 read ", tag}, {a[15:0], v}, {a[15:0], e});
      a = o ? (a + 1) % 128 : (a + 1) % 256;
    end
    cs = 1'b0; tick(2 * H);
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503) ^ 16'h3C5A);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 16'hFFFF;
    tick(5); rst_n = 1'b1; tick(5);
    // R4: reset state
    chk(!oe_w, "R4 output disabled after reset", oe_w, 0);
    read_seq(1'b1, 5, 2, "R4 erased after reset");

    // R5: write while locked is ignored
    prog_cmd(1'b1, 2'b01, 9'd3, 16'h1234, 16, 0);
    no_launch("R5 locked write no cycle");
    read_seq(1'b1, 3, 1, "R5 locked write ignored");

    // R5: unlock, then R7 write
    prog_cmd(1'b1, 2'b00, ext_raw(1'b1, 2'b11), 16'h0, 0, 0);
    no_launch("R5 unlock has no busy cycle");
    prog_cmd(1'b1, 2'b01, 9'd3, 16'h1234, 16, 0);
    wait_prog("write");
    shadow[3] = 16'h1234;
    read_seq(1'b1, 3, 1, "R7 write word");

    // R9: lock frame during busy is ignored
    prog_cmd(1'b1, 2'b01, 9'd4, 16'hAAAA, 16, 0);
    tick(8);
    header(1'b1, 2'b00, ext_raw(1'b1, 2'b00), 0);
    cs = 1'b0; tick(8);
    cs = 1'b1;
    for (int i = 0; i < PC + 50 && !(oe_w && do_w); i++) tick(1);
    cs = 1'b0; tick(2 * H);
    shadow[4] = 16'hAAAA;
    prog_cmd(1'b1, 2'b01, 9'd6, 16'h7777, 16, 0);
    wait_prog("R9 still unlocked");
    shadow[6] = 16'h7777;
    read_seq(1'b1, 4, 3, "R9 busy frame ignored");

    // R6: truncated frame dropped, leading zeros skipped
    prog_cmd(1'b1, 2'b01, 9'd7, 16'h0BAD, 10, 0);
    no_launch("R6 short frame no cycle");
    prog_cmd(1'b1, 2'b01, 9'd8, 16'hC0DE, 16, 3);
    wait_prog("R1 leading zeros");
    shadow[8] = 16'hC0DE;
    read_seq(1'b1, 7, 2, "R6 short dropped, R1 leading zeros");

    // R7: single erase
    prog_cmd(1'b1, 2'b11, 9'd3, 16'h0, 0, 0);
    wait_prog("erase");
    shadow[3] = 16'hFFFF;
    read_seq(1'b1, 3, 1, "R7 erase word");

    // Sweep: every word, then wrap at 127 (R3) and byte view (R1)
    for (int a = 0; a < 128; a++) begin
      prog_cmd(1'b1, 2'b01, 9'(a), pat(a), 16, 0);
      wait_prog("sweep");
      shadow[a] = pat(a);
    end
    read_seq(1'b1, 126, 130, "R3 x16 sweep wrap");
    read_seq(1'b0, 254, 258, "R1 R3 x8 sweep wrap");

    // R7 in 8-bit view: byte write and byte erase
    prog_cmd(1'b0, 2'b01, 9'd9, 16'h003C, 8, 0);
    wait_prog("x8 write");
    shadow[4][15:8] = 8'h3C;
    prog_cmd(1'b0, 2'b11, 9'd10, 16'h0, 0, 0);
    wait_prog("x8 erase");
    shadow[5][7:0] = 8'hFF;
    read_seq(1'b1, 4, 2, "R7 x8 byte lanes");

    // R7: whole-array erase and fill
    prog_cmd(1'b1, 2'b00, ext_raw(1'b1, 2'b10), 16'h0, 0, 0);
    wait_prog("eral");
    for (int i = 0; i < 128; i++) shadow[i] = 16'hFFFF;
    read_seq(1'b1, 126, 4, "R7 erase all");
    prog_cmd(1'b1, 2'b00, ext_raw(1'b1, 2'b01), 16'hBEEF, 16, 0);
    wait_prog("wral x16");
    for (int i = 0; i < 128; i++) shadow[i] = 16'hBEEF;
    read_seq(1'b1, 60, 4, "R7 fill x16");
    prog_cmd(1'b0, 2'b00, ext_raw(1'b0, 2'b01), 16'h005A, 8, 0);
    wait_prog("wral x8");
    for (int i = 0; i < 128; i++) shadow[i] = 16'h5A5A;
    read_seq(1'b1, 0, 3, "R7 fill x8");

    // R5: lock again, whole-array erase ignored
    prog_cmd(1'b1, 2'b00, ext_raw(1'b1, 2'b00), 16'h0, 0, 0);
    tick(2 * H);
    prog_cmd(1'b1, 2'b00, ext_raw(1'b1, 2'b10), 16'h0, 0, 0);
    no_launch("R5 locked erase-all no cycle");
    read_seq(1'b1, 90, 2, "R5 locked erase-all ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule